// File: doc/BRIEF.md
# Output Conflict Status and Interrupt Unit

This block keeps the per-output conflict status of a 16-output timer and turns it into one interrupt request. The event engine reports a no-change conflict as a one-cycle pulse on the output's line. The block then holds a sticky flag for that output until software writes a one to that flag bit. An enable register with one bit per output selects which flags may raise the interrupt. The interrupt output is registered.

The same status word also carries two sticky bits that name the counter half behind the most recent bus error. One bit covers the low (or unified) half and the other covers the high half. A word write that spans both halves can fail in one half only, so the two error inputs are sampled independently. Any new error event replaces both bits.

Software reaches the block through a plain word-wide port. It has a write strobe with its own address and data, and a combinational read path with its own address. Word 0 is the enable register and word 1 is the status register. There is no data stream and so no valid/ready handshake: every pin is a plain control or status signal, and a write is accepted in the cycle its strobe is high.

Top module: `nochg_conflict_status`

## Requirements
- R1: After reset the enable register, every conflict flag, both bus-error bits and the interrupt output are 0.
- R2: A high on conflict input bit n sets status bit n at the next clock edge. The bit then stays set when no clear is written.
- R3: A write to word 1 clears each status bit n in 0..15 whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: When a conflict pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to word 0 loads enable bits 15..0 from write-data bits 15..0. Reading word 0 returns them with bits 31..16 as zero.
- R6: The interrupt output is high exactly one clock after a cycle in which some bit n has both enable n and status n set, and low one clock after a cycle in which none has.
- R7: In a cycle where either bus-error input is high, status bit 30 takes the low-half error input and bit 31 takes the high-half error input. Both bits hold while neither input is high.
- R8: The two bus-error inputs are recorded independently, so status bits 30 and 31 can read 01, 10 or 11 in binary (bit 31 first).
- R9: Writing ones to status bits 31..16 has no effect, and status bits 29..16 always read as zero.
- R10: Reads of words 2 and 3 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| conflict_i | input | 16 | Per-output conflict pulse from the event engine |
| buserr_lo_i | input | 1 | Bus error reported against the low/unified half |
| buserr_hi_i | input | 1 | Bus error reported against the high half |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties treat the conflict and bus-error inputs as synchronous levels that are sampled at each rising edge. A pulse wider than one cycle simply re-sets the flag or reloads the error bits. They also assume the write port carries a defined address whenever the strobe is high. The bench drives every input at the falling edge, holds each event for exactly one cycle and returns strobes to zero before the next step. Every address it uses is one of the four decoded words, so each property sees clean single-cycle events.

// File: rtl/ncs_pkg.sv
package ncs_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    WORD_ENABLE = 2'd0,
    WORD_STATUS = 2'd1,
    WORD_SPARE2 = 2'd2,
    WORD_SPARE3 = 2'd3
  } word_sel_e;
endpackage

// File: rtl/conflict_flag_bank.sv
module conflict_flag_bank #(
  parameter int NUM_OUT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] set_i,
  input  logic [NUM_OUT-1:0] clr_i,
  output logic [NUM_OUT-1:0] flags_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_bit
    // set has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);

    assert_clear_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);

    assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[g] && !clr_i[g]) |=> $stable(flags_o[g]));
  end
endmodule

// File: rtl/bus_err_latch.sv
module bus_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_lo_i,
  input  logic ev_hi_i,
  output logic err_lo_o,
  output logic err_hi_o
);
  logic any_ev;
  assign any_ev = ev_lo_i | ev_hi_i;

  // any new event rewrites both bits so they describe only the latest error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_lo_o <= 1'b0;
      err_hi_o <= 1'b0;
    end else if (any_ev) begin
      err_lo_o <= ev_lo_i;
      err_hi_o <= ev_hi_i;
    end
  end

  assert_err_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lo_i || ev_hi_i) |=> (err_lo_o == $past(ev_lo_i)) && (err_hi_o == $past(ev_hi_i)));

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_lo_i || ev_hi_i) |=> $stable({err_hi_o, err_lo_o}));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_OUT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en_i,
  input  logic [NUM_OUT-1:0] flag_i,
  output logic               irq_o
);
  logic [NUM_OUT-1:0] live;
  assign live = en_i & flag_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |live;
  end

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_i & flag_i)) |=> irq_o);

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(en_i & flag_i)) |=> !irq_o);
endmodule

// File: rtl/nochg_conflict_status.sv
module nochg_conflict_status
  import ncs_pkg::*;
#(
  parameter int NUM_OUT = 16,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_OUT-1:0]  conflict_i,
  input  logic                buserr_lo_i,
  input  logic                buserr_hi_i,
  output logic                irq_o
);
  localparam int ERR_LO_POS = DATA_W - 2;
  localparam int ERR_HI_POS = DATA_W - 1;

  logic [NUM_OUT-1:0] enable_q;
  logic [NUM_OUT-1:0] flags;
  logic [NUM_OUT-1:0] clr_mask;
  logic               err_lo, err_hi;
  logic               wr_enable_word, wr_status_word;
  logic               unused_wr_upper;

  assign wr_enable_word  = wr_en && (word_sel_e'(wr_addr) == WORD_ENABLE);
  assign wr_status_word  = wr_en && (word_sel_e'(wr_addr) == WORD_STATUS);
  assign clr_mask        = wr_status_word ? wr_data[NUM_OUT-1:0] : '0;
  assign unused_wr_upper = ^wr_data[DATA_W-1:NUM_OUT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              enable_q <= '0;
    else if (wr_enable_word) enable_q <= wr_data[NUM_OUT-1:0];
  end

  conflict_flag_bank #(.NUM_OUT(NUM_OUT)) flag_bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (conflict_i),
    .clr_i   (clr_mask),
    .flags_o (flags)
  );

  bus_err_latch err_latch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_lo_i  (buserr_lo_i),
    .ev_hi_i  (buserr_hi_i),
    .err_lo_o (err_lo),
    .err_hi_o (err_hi)
  );

  irq_gate #(.NUM_OUT(NUM_OUT)) irq_gate_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (enable_q),
    .flag_i (flags),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_data = '0;
    case (word_sel_e'(rd_addr))
      WORD_ENABLE: rd_data[NUM_OUT-1:0] = enable_q;
      WORD_STATUS: begin
        rd_data[NUM_OUT-1:0] = flags;
        rd_data[ERR_LO_POS]  = err_lo;
        rd_data[ERR_HI_POS]  = err_hi;
      end
      default:     rd_data = '0;
    endcase
  end

  // a status write with no conflict pulse never sets a flag
  assert_write_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|conflict_i) |=> ((flags & ~$past(flags)) == '0));

  assert_enable_only_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable_word |=> $stable(enable_q));
endmodule

// File: tb/nochg_conflict_status_tb_top.sv
module nochg_conflict_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] conflict_i = '0;
  logic        buserr_lo_i = 1'b0;
  logic        buserr_hi_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nochg_conflict_status dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .conflict_i(conflict_i),
    .buserr_lo_i(buserr_lo_i), .buserr_hi_i(buserr_hi_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [15:0] conf;
    logic        elo;
    logic        ehi;
    logic [15:0] exp_en;
    logic [31:0] exp_stat;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 32'h0000_00FF, 16'h0000, 1'b0, 1'b0, 16'h00FF, 32'h0000_0000, 1'b0}, // R5
    '{1'b0, 2'd0, 32'h0000_0000, 16'h0101, 1'b0, 1'b0, 16'h00FF, 32'h0000_0101, 1'b1}, // R2 R6
    '{1'b1, 2'd1, 32'h0000_0001, 16'h0000, 1'b0, 1'b0, 16'h00FF, 32'h0000_0100, 1'b0}, // R3 R6
    '{1'b1, 2'd0, 32'hFFFF_FF00, 16'h0000, 1'b0, 1'b0, 16'hFF00, 32'h0000_0100, 1'b1}, // R5 R6
    '{1'b0, 2'd0, 32'h0000_0000, 16'h0000, 1'b1, 1'b0, 16'hFF00, 32'h4000_0100, 1'b1}, // R7
    '{1'b0, 2'd0, 32'h0000_0000, 16'h0000, 1'b0, 1'b1, 16'hFF00, 32'h8000_0100, 1'b1}, // R7
    '{1'b0, 2'd0, 32'h0000_0000, 16'h0000, 1'b1, 1'b1, 16'hFF00, 32'hC000_0100, 1'b1}, // R8
    '{1'b1, 2'd1, 32'hFFFF_0000, 16'h0000, 1'b0, 1'b0, 16'hFF00, 32'hC000_0100, 1'b1}, // R9
    '{1'b1, 2'd2, 32'hFFFF_FFFF, 16'h0000, 1'b0, 1'b0, 16'hFF00, 32'hC000_0100, 1'b1}, // R10
    '{1'b1, 2'd1, 32'h0000_0100, 16'h0000, 1'b0, 1'b0, 16'hFF00, 32'hC000_0000, 1'b0}, // R3
    '{1'b1, 2'd0, 32'h0000_0000, 16'h8000, 1'b0, 1'b0, 16'h0000, 32'hC000_8000, 1'b0}  // R2 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic drive(input logic w, input logic [1:0] a, input logic [31:0] d,
                       input logic [15:0] c, input logic lo, input logic hi);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; conflict_i = c; buserr_lo_i = lo; buserr_hi_i = hi;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; conflict_i = '0; buserr_lo_i = 1'b0; buserr_hi_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_word(2'd0, d); check("R1 enable", d, 32'h0);
    read_word(2'd1, d); check("R1 status", d, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].conf, VECS[i].elo, VECS[i].ehi);
      @(negedge clk);
      read_word(2'd0, d); check("R5 vector enable", d, {16'h0, VECS[i].exp_en});
      read_word(2'd1, d); check("R2/R3/R7 vector status", d, VECS[i].exp_stat);
      check("R6 vector irq", {31'h0, irq_o}, {31'h0, VECS[i].exp_irq});
    end

    // R4: set and clear of bit 3 in the same cycle, set wins
    drive(1'b1, 2'd1, 32'h0000_0008, 16'h0008, 1'b0, 1'b0);
    read_word(2'd1, d); check("R4 set beats clear", d, 32'hC000_8008);

    // R6 latency: enable bit 3 while its flag is set
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0000_0008;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check("R6 irq not yet", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    check("R6 irq one clock later", {31'h0, irq_o}, 32'h1);

    // R10: spare words read zero
    read_word(2'd2, d); check("R10 word2 read", d, 32'h0);
    read_word(2'd3, d); check("R10 word3 read", d, 32'h0);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_word(2'd0, d); check("R1 enable after reset", d, 32'h0);
    read_word(2'd1, d); check("R1 status after reset", d, 32'h0);
    check("R1 irq after reset", {31'h0, irq_o}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule